// File: doc/BRIEF.md
# Exception Resume Address Register with Mode Packing

This block holds the address at which a core resumes after an exception. The core can run two instruction encodings, a full-width one and a compressed one, and it needs to know which encoding to use on return. The register packs that information into the address itself. On exception entry the hardware capture port writes the resume address. Address bit 0 is dropped, and the current mode bit is stored in that position instead.

On exception return the restore outputs split the stored word into two parts: a halfword-aligned PC whose bit 0 is always zero, and a mode bit taken from bit 0. A separate software port reads and writes the raw word with no interpretation. A value written by software is therefore decoded by later restores in the same way as a value from a hardware capture. If a capture and a software write fall in the same cycle, the capture is stored.

Top module: `epc_mode_reg`

## Requirements
- R1: After reset is released, the software read data and the restore PC read zero and the restore mode bit reads 0.
- R2: A hardware capture stores capture PC bits [W-1:1] in bits [W-1:1] and the capture mode bit in bit 0. The stored word is visible on the outputs in the next cycle.
- R3: The restore PC output equals stored bits [W-1:1], followed by a 0 in bit 0.
- R4: The restore mode output equals stored bit 0.
- R5: A software read returns the last stored word unchanged.
- R6: A software write stores all W bits. Later restores split that word as in R3 and R4.
- R7: When a capture and a software write occur in the same cycle, the capture value is stored and the software data is discarded.
- R8: While neither a capture nor a software write is active, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_valid_i | input | 1 | Hardware capture strobe, asserted on exception entry |
| cap_pc_i | input | W | Resume address to capture |
| cap_mode_i | input | 1 | Current mode bit to capture (1 = compressed encoding) |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | W | Software write data |
| sw_rdata_o | output | W | Raw stored word |
| rst_pc_o | output | W | Restore PC, halfword aligned |
| rst_mode_o | output | 1 | Restore mode bit |

## Verification
The stored word drives every output one cycle after it is written. A wrong value in it therefore shows on the raw read port at the next sample. A fault in the stored bit 0 alone shows up differently on each output: it changes the mode output and the raw read, while the restore PC stays even. The bench sweeps the low address bits against both modes on capture and on software write, and checks the effect of every write in the cycle after it. It also checks the write-collision and idle cycles. A wrong priority or a lost hold would change the read value in the cycle after the stimulus.

// File: rtl/epc_mode_pkg.sv
package epc_mode_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SW   = 2'd1,
    SRC_CAP  = 2'd2
  } epc_src_e;
endpackage

// File: rtl/epc_wr_sel.sv
module epc_wr_sel
  import epc_mode_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         cap_valid_i,
  input  logic [W-1:0] cap_pc_i,
  input  logic         cap_mode_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic [W-1:0] cur_i,
  output epc_src_e     src_o,
  output logic [W-1:0] next_o
);
  always_comb begin
    if (cap_valid_i)  src_o = SRC_CAP;   // hardware capture has priority
    else if (sw_we_i) src_o = SRC_SW;
    else              src_o = SRC_HOLD;
  end

  always_comb begin
    unique case (src_o)
      SRC_CAP: next_o = {cap_pc_i[W-1:1], cap_mode_i};
      SRC_SW:  next_o = sw_wdata_i;
      default: next_o = cur_i;
    endcase
  end

  always_comb begin
    assert_prio_R7: assert (!(cap_valid_i && sw_we_i) || src_o == SRC_CAP);
  end
endmodule

// File: rtl/epc_split.sv
module epc_split #(
  parameter int W = 32
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] pc_o,
  output logic         mode_o
);
  assign pc_o   = {word_i[W-1:1], 1'b0};
  assign mode_o = word_i[0];

  always_comb begin
    assert_pc_even_R3: assert (pc_o[0] == 1'b0);
  end
endmodule

// File: rtl/epc_mode_reg.sv
module epc_mode_reg
  import epc_mode_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_valid_i,
  input  logic [W-1:0] cap_pc_i,
  input  logic         cap_mode_i,
  input  logic         sw_we_i,
  input  logic [W-1:0] sw_wdata_i,
  output logic [W-1:0] sw_rdata_o,
  output logic [W-1:0] rst_pc_o,
  output logic         rst_mode_o
);
  logic [W-1:0] epc_q, epc_d;
  epc_src_e     src;

  epc_wr_sel #(.W(W)) u_sel (
    .cap_valid_i(cap_valid_i), .cap_pc_i(cap_pc_i), .cap_mode_i(cap_mode_i),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i), .cur_i(epc_q),
    .src_o(src), .next_o(epc_d)
  );

  // reset value is architecturally undefined; zero for determinism
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) epc_q <= '0;
    else         epc_q <= epc_d;
  end

  assign sw_rdata_o = epc_q;

  epc_split #(.W(W)) u_split (
    .word_i(epc_q), .pc_o(rst_pc_o), .mode_o(rst_mode_o)
  );

  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_i |=> sw_rdata_o == {$past(cap_pc_i[W-1:1]), $past(cap_mode_i)});
  assert_sw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !cap_valid_i) |=> sw_rdata_o == $past(sw_wdata_i));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_we_i && !cap_valid_i) |=> $stable(sw_rdata_o));
  assert_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_mode_o == sw_rdata_o[0]);
  assert_pc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pc_o[W-1:1] == sw_rdata_o[W-1:1]);
endmodule

// File: tb/tb_epc_mode_reg.sv
module tb_epc_mode_reg;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0;
  logic cap_valid = 0, cap_mode = 0, sw_we = 0;
  logic [W-1:0] cap_pc = '0, sw_wdata = '0;
  logic [W-1:0] sw_rdata, rst_pc;
  logic rst_mode;
  int total = 0, bad = 0;
  logic [W-1:0] model = '0;

  epc_mode_reg #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cap_valid_i(cap_valid), .cap_pc_i(cap_pc),
    .cap_mode_i(cap_mode), .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
    .sw_rdata_o(sw_rdata), .rst_pc_o(rst_pc), .rst_mode_o(rst_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " R5 rdata"}, sw_rdata, model);
    chk({req, " R3 pc"}, rst_pc, {model[W-1:1], 1'b0});
    chk({req, " R4 mode"}, {{(W-1){1'b0}}, rst_mode}, {{(W-1){1'b0}}, model[0]});
  endtask

  // drive at negedge, register at posedge, sample at next negedge
  task automatic step(logic cv, logic [W-1:0] cp, logic cm, logic sw, logic [W-1:0] sd);
    cap_valid = cv; cap_pc = cp; cap_mode = cm; sw_we = sw; sw_wdata = sd;
    if (cv) model = {cp[W-1:1], cm};
    else if (sw) model = sd;
    @(negedge clk);
    cap_valid = 0; sw_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_all("R1");
    for (int m = 0; m < 2; m++)
      for (int lo = 0; lo < 16; lo++) begin
        logic [W-1:0] pc = 32'hA5C3_0000 ^ (32'h1357_9BD0 * lo) | lo[W-1:0];
        step(1, pc, m[0], 0, '0);
        check_all("R2");
        chk("R2 pc_keeps", rst_pc, {pc[W-1:1], 1'b0});
      end
    for (int lo = 0; lo < 32; lo++) begin
      logic [W-1:0] d = 32'hDEAD_BEE0 + lo * 32'h0101_0101 + lo;
      step(0, '0, 0, 1, d);
      check_all("R6");
      chk("R5 raw", sw_rdata, d);
    end
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] pc = 32'h8000_1000 + k * 3;
      step(1, pc, k[0], 1, ~pc);
      check_all("R7");
      chk("R7 cap_wins", sw_rdata, {pc[W-1:1], k[0]});
    end
    for (int k = 0; k < 4; k++) begin
      step(0, 32'hFFFF_FFFF, 1, 0, 32'h1234_5677);
      check_all("R8");
    end
    step(0, '0, 0, 1, 32'hFFFF_FFFF);
    check_all("R6 ones");
    step(0, '0, 0, 1, 32'h0000_0001);
    check_all("R4 only_bit0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule